// File: doc/BRIEF.md
# Dual Compute-Unit Tile Dispatcher

This block sequences the convolution tiles of one layer across two compute units of unequal size. A layer descriptor carries two tile counts. The first count is for the slow unit, which is the larger one. The second count is for the fast unit, which is the smaller one. The block accepts the descriptor while idle and then runs a series of rounds. Each round has three phases in a fixed order: a load phase, a compute phase and a store phase.

In the load phase the weight mover and the feature mover start together. In the compute phase each unit that still has a tile in this round is started. In the store phase the result mover writes the round's output back. Every phase is a barrier: the next phase, and the next round, begin only after every engine started in the current phase has reported done.

Every engine is reached through a one-cycle start pulse and a sticky done level. An engine must drop its done level no later than the cycle after it sees a start. A flag in the descriptor marks a fused convolution, activation and pooling layer. In a fused layer the features are loaded once, at the beginning, and results are stored once, at the end. When the layer completes, the block raises a done pulse and presents the number of clock cycles the layer took.

Top module: `tile_dispatch_top`

## Requirements
- R1: After reset, `desc_ready` is 1 and every start output, `layer_done` and `layer_cycles` are 0.
- R2: A descriptor is taken only on a cycle with `desc_valid` and `desc_ready` both high. `desc_ready` is low from that edge until the layer completes. A descriptor presented while the block is busy has no effect.
- R3: In each round, `wload_start` and `fload_start` (when a feature load is due) pulse in the same cycle. No unit start occurs until both loaders have reported done.
- R4: The number of rounds equals the larger of the two counts. Unit 1 receives a tile in round r (counting from 0) exactly when r < num1, and unit 2 exactly when r < num2. When both receive a tile in a round, both starts pulse in the same cycle, so there are min(num1, num2) paired starts.
- R5: No phase starts before every engine started in the previous phase has reported done. A store never overlaps a running unit, and a load never overlaps a running unit or store. No engine is restarted while it is still running.
- R6: In an unfused layer (`desc_fused`=0), `store_start` pulses once per round, after the units of that round have finished.
- R7: In a fused layer (`desc_fused`=1), `fload_start` pulses only in round 0 and `store_start` pulses only in the last round. `wload_start` still pulses once per round.
- R8: A descriptor with num1 = num2 = 0 starts no engine. It raises `layer_done` in the cycle after it is accepted, with `layer_cycles` = 0.
- R9: `layer_done` is a one-cycle pulse, and `desc_ready` is 1 in the cycle after it. `layer_cycles` equals the number of rising clock edges after the accepting edge, up to and including the edge that raises `layer_done`. That value is held until the next layer completes.
- R10: Every start output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, able to take a descriptor |
| desc_num1 | input | CNT_W | Tiles for unit 1 (slow, large) |
| desc_num2 | input | CNT_W | Tiles for unit 2 (fast, small) |
| desc_fused | input | 1 | Fused layer: one feature load, one final store |
| wload_start | output | 1 | Start pulse for the weight mover |
| wload_done | input | 1 | Sticky done from the weight mover |
| fload_start | output | 1 | Start pulse for the feature mover |
| fload_done | input | 1 | Sticky done from the feature mover |
| cu1_start | output | 1 | Start pulse for unit 1 |
| cu1_done | input | 1 | Sticky done from unit 1 |
| cu2_start | output | 1 | Start pulse for unit 2 |
| cu2_done | input | 1 | Sticky done from unit 2 |
| store_start | output | 1 | Start pulse for the result mover |
| store_done | input | 1 | Sticky done from the result mover |
| layer_done | output | 1 | One-cycle pulse when the layer completes |
| layer_cycles | output | CYC_W | Cycle count of the last completed layer |

## Verification
Suppose the round counter or the latched counts went wrong. The bench would then see too many or too few start pulses on one unit, or too few paired starts, and it would see this by the end of that layer. A done record that is not cleared, or that samples an engine outside its own phase, would let a phase begin while an engine model is still busy. The bench would flag that on the very cycle of the early start pulse. Errors in the fused-layer masks show up as wrong loader or store totals, and errors in the cycle counter show up as a mismatch with the bench's own edge count at `layer_done`.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_COMP,
      ST_STORE,
      ST_FIN
   } tdisp_state_e;

   localparam int unsigned ENG_NUM = 5;
   localparam int unsigned ENG_WL  = 0;
   localparam int unsigned ENG_FL  = 1;
   localparam int unsigned ENG_U1  = 2;
   localparam int unsigned ENG_U2  = 3;
   localparam int unsigned ENG_ST  = 4;
endpackage

// File: rtl/tdisp_round_plan.sv
module tdisp_round_plan #(
   parameter int unsigned CNT_W = 8
) (
   input  logic [CNT_W-1:0] n1,
   input  logic [CNT_W-1:0] n2,
   input  logic [CNT_W-1:0] rnd,
   input  logic             fused,
   output logic [CNT_W-1:0] tot,
   output logic             u1_act,
   output logic             u2_act,
   output logic             last_rnd,
   output logic             need_feat,
   output logic             need_store
);
   logic first_rnd;

   always_comb begin
      tot        = (n1 > n2) ? n1 : n2;
      u1_act     = rnd < n1;
      u2_act     = rnd < n2;
      first_rnd  = rnd == '0;
      last_rnd   = ({1'b0, rnd} + 1'b1) == {1'b0, tot};
      need_feat  = !fused || first_rnd;
      need_store = !fused || last_rnd;
   end
endmodule

// File: rtl/tdisp_done_rec.sv
module tdisp_done_rec #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         issue,
   input  logic [N-1:0] done_i,
   input  logic [N-1:0] need,
   output logic         all_done
);
   logic [N-1:0] rec_q;
   logic [N-1:0] seen;

   for (genvar gi = 0; gi < N; gi++) begin : g_bit
      always_comb seen[gi] = rec_q[gi] | (done_i[gi] & need[gi] & ~issue);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   rec_q[gi] <= 1'b0;
         else if (clr) rec_q[gi] <= 1'b0;
         else          rec_q[gi] <= seen[gi];
      end
   end

   assign all_done = &(seen | ~need);
endmodule

// File: rtl/tdisp_cycle_ctr.sv
module tdisp_cycle_ctr #(
   parameter int unsigned W        = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt
);
   if (SATURATE) begin : g_sat
      always_comb cnt_nxt = (&cnt) ? cnt : cnt + 1'b1;
   end else begin : g_wrap
      always_comb cnt_nxt = cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt_nxt;
   end
endmodule

// File: rtl/tile_dispatch_top.sv
module tile_dispatch_top
   import tdisp_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned CYC_W        = 32,
   parameter bit          CYC_SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             desc_valid,
   output logic             desc_ready,
   input  logic [CNT_W-1:0] desc_num1,
   input  logic [CNT_W-1:0] desc_num2,
   input  logic             desc_fused,
   output logic             wload_start,
   input  logic             wload_done,
   output logic             fload_start,
   input  logic             fload_done,
   output logic             cu1_start,
   input  logic             cu1_done,
   output logic             cu2_start,
   input  logic             cu2_done,
   output logic             store_start,
   input  logic             store_done,
   output logic             layer_done,
   output logic [CYC_W-1:0] layer_cycles
);
   localparam int unsigned ENG = ENG_NUM;

   initial begin
      if (CNT_W < 1 || CNT_W > 16) $fatal(1, "CNT_W out of range");
      if (CYC_W < 8 || CYC_W > 64) $fatal(1, "CYC_W out of range");
   end

   tdisp_state_e     state_q;
   logic [CNT_W-1:0] n1_q, n2_q, rnd_q;
   logic             fused_q, issue_q;
   logic [CYC_W-1:0] cyc_q;

   logic [CNT_W-1:0] tot;
   logic             u1_act, u2_act, last_rnd, need_feat, need_store;
   logic [ENG-1:0]   need, done_vec, start_vec;
   logic             all_done, accept, zero_desc, rnd_start, busy, next_round;
   logic [CYC_W-1:0] cnt, cnt_nxt;

   tdisp_round_plan #(.CNT_W(CNT_W)) u_plan (
      .n1(n1_q), .n2(n2_q), .rnd(rnd_q), .fused(fused_q),
      .tot(tot), .u1_act(u1_act), .u2_act(u2_act), .last_rnd(last_rnd),
      .need_feat(need_feat), .need_store(need_store)
   );

   assign accept    = (state_q == ST_IDLE) && desc_valid;
   assign zero_desc = (desc_num1 == '0) && (desc_num2 == '0);
   assign busy      = (state_q == ST_LOAD) || (state_q == ST_COMP) || (state_q == ST_STORE);

   always_comb begin
      done_vec         = '0;
      done_vec[ENG_WL] = wload_done;
      done_vec[ENG_FL] = fload_done;
      done_vec[ENG_U1] = cu1_done;
      done_vec[ENG_U2] = cu2_done;
      done_vec[ENG_ST] = store_done;
   end

   always_comb begin
      need = '0;
      unique case (state_q)
         ST_LOAD: begin
            need[ENG_WL] = 1'b1;
            need[ENG_FL] = need_feat;
         end
         ST_COMP: begin
            need[ENG_U1] = u1_act;
            need[ENG_U2] = u2_act;
         end
         ST_STORE: need[ENG_ST] = 1'b1;
         default:  need = '0;
      endcase
   end

   assign next_round = all_done && !last_rnd &&
                       (((state_q == ST_COMP) && !need_store) || (state_q == ST_STORE));
   assign rnd_start  = (accept && !zero_desc) || next_round;

   tdisp_done_rec #(.N(ENG)) u_rec (
      .clk(clk), .rst_n(rst_n), .clr(rnd_start), .issue(issue_q),
      .done_i(done_vec), .need(need), .all_done(all_done)
   );

   tdisp_cycle_ctr #(.W(CYC_W), .SATURATE(CYC_SATURATE)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(busy),
      .cnt(cnt), .cnt_nxt(cnt_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         n1_q    <= '0;
         n2_q    <= '0;
         rnd_q   <= '0;
         fused_q <= 1'b0;
         issue_q <= 1'b0;
         cyc_q   <= '0;
      end else begin
         issue_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               n1_q    <= desc_num1;
               n2_q    <= desc_num2;
               fused_q <= desc_fused;
               rnd_q   <= '0;
               if (zero_desc) begin
                  state_q <= ST_FIN;
                  cyc_q   <= '0;
               end else begin
                  state_q <= ST_LOAD;
                  issue_q <= 1'b1;
               end
            end
            ST_LOAD: if (all_done) begin
               state_q <= ST_COMP;
               issue_q <= 1'b1;
            end
            ST_COMP, ST_STORE: if (all_done) begin
               if ((state_q == ST_COMP) && need_store) begin
                  state_q <= ST_STORE;
                  issue_q <= 1'b1;
               end else if (last_rnd) begin
                  state_q <= ST_FIN;
                  cyc_q   <= cnt_nxt;
               end else begin
                  rnd_q   <= rnd_q + 1'b1;
                  state_q <= ST_LOAD;
                  issue_q <= 1'b1;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign start_vec    = issue_q ? need : '0;
   assign wload_start  = start_vec[ENG_WL];
   assign fload_start  = start_vec[ENG_FL];
   assign cu1_start    = start_vec[ENG_U1];
   assign cu2_start    = start_vec[ENG_U2];
   assign store_start  = start_vec[ENG_ST];
   assign desc_ready   = state_q == ST_IDLE;
   assign layer_done   = state_q == ST_FIN;
   assign layer_cycles = cyc_q;
endmodule

// File: rtl/tdisp_chk.sv
module tdisp_chk #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned CYC_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             desc_valid,
   input logic             desc_ready,
   input logic [CNT_W-1:0] desc_num1,
   input logic [CNT_W-1:0] desc_num2,
   input logic             wload_start,
   input logic             fload_start,
   input logic             cu1_start,
   input logic             cu2_start,
   input logic             store_start,
   input logic             layer_done,
   input logic [CYC_W-1:0] layer_cycles
);
   a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_ready |=> !desc_ready);
   a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      layer_done |=> desc_ready);
   a_r3_feat_with_weight: assert property (@(posedge clk) disable iff (!rst_n)
      fload_start |-> wload_start);
   a_r5_load_alone: assert property (@(posedge clk) disable iff (!rst_n)
      wload_start |-> !(cu1_start || cu2_start || store_start));
   a_r5_store_alone: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |-> !(cu1_start || cu2_start));
   a_r8_zero_layer: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_ready && desc_num1 == '0 && desc_num2 == '0
      |=> layer_done && !wload_start && !cu1_start && !cu2_start);
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      layer_done |=> !layer_done);
   a_r9_cycles_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !layer_done |-> $stable(layer_cycles));
   a_r10_wload_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wload_start |=> !wload_start);
   a_r10_cu1_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cu1_start |=> !cu1_start);
   a_r10_cu2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cu2_start |=> !cu2_start);
   a_r10_store_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |=> !store_start);
endmodule

bind tile_dispatch_top tdisp_chk #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
   .desc_num1(desc_num1), .desc_num2(desc_num2), .wload_start(wload_start),
   .fload_start(fload_start), .cu1_start(cu1_start), .cu2_start(cu2_start),
   .store_start(store_start), .layer_done(layer_done), .layer_cycles(layer_cycles)
);

// File: tb/tb_tile_dispatch_top.sv
module tb_tile_dispatch_top;
   localparam int unsigned CNT_W = 8;
   localparam int unsigned CYC_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic desc_valid = 1'b0;
   logic [CNT_W-1:0] desc_num1 = '0, desc_num2 = '0;
   logic desc_fused = 1'b0;
   logic desc_ready, layer_done;
   logic wload_start, fload_start, cu1_start, cu2_start, store_start;
   logic [CYC_W-1:0] layer_cycles;
   logic [4:0] eng_done = '0;
   logic [4:0] eng_busy = '0;
   int eng_left [5];
   int starts [5];
   int paired, viol;
   int total = 0, bad = 0;
   bit wd_hit = 1'b0;

   always #5 clk = ~clk;

   tile_dispatch_top #(.CNT_W(CNT_W), .CYC_W(CYC_W)) dut (
      .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_num1(desc_num1), .desc_num2(desc_num2), .desc_fused(desc_fused),
      .wload_start(wload_start), .wload_done(eng_done[0]),
      .fload_start(fload_start), .fload_done(eng_done[1]),
      .cu1_start(cu1_start), .cu1_done(eng_done[2]),
      .cu2_start(cu2_start), .cu2_done(eng_done[3]),
      .store_start(store_start), .store_done(eng_done[4]),
      .layer_done(layer_done), .layer_cycles(layer_cycles)
   );

   // Engine models with random latency; protocol watch for R3/R5
   always @(negedge clk) begin
      logic [4:0] sv;
      sv = {store_start, cu2_start, cu1_start, fload_start, wload_start};
      if (rst_n) begin
         if ((sv[2] || sv[3]) && (eng_busy[0] || eng_busy[1] || eng_busy[4])) viol++;
         if (sv[4] && (eng_busy[2] || eng_busy[3])) viol++;
         if (sv[0] && (eng_busy[2] || eng_busy[3] || eng_busy[4])) viol++;
         if (sv[2] && sv[3]) paired++;
         for (int i = 0; i < 5; i++) begin
            if (sv[i] && eng_busy[i]) viol++;
            if (sv[i]) begin
               int lat;
               starts[i]++;
               lat = int'($urandom % 4);
               if (lat == 0) begin
                  eng_done[i] = 1'b1; eng_busy[i] = 1'b0;
               end else begin
                  eng_done[i] = 1'b0; eng_busy[i] = 1'b1; eng_left[i] = lat;
               end
            end else if (eng_busy[i]) begin
               eng_left[i]--;
               if (eng_left[i] == 0) begin
                  eng_done[i] = 1'b1; eng_busy[i] = 1'b0;
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic run_layer(input int n1, input int n2, input bit fu);
      int meas, rounds;
      rounds = max2(n1, n2);
      @(negedge clk);
      while (!desc_ready && !wd_hit) @(negedge clk);
      for (int i = 0; i < 5; i++) starts[i] = 0;
      paired = 0; viol = 0;
      desc_valid = 1'b1; desc_num1 = CNT_W'(n1); desc_num2 = CNT_W'(n2); desc_fused = fu;
      @(negedge clk);
      desc_valid = 1'b0;
      meas = 0;
      if (rounds == 0) begin
         chk(layer_done == 1'b1, "R8 done after zero layer", layer_done, 1);
      end else begin
         // R2: offer a bogus descriptor while busy
         chk(desc_ready == 1'b0, "R2 ready low when busy", desc_ready, 0);
         desc_valid = 1'b1; desc_num1 = 8'd200; desc_num2 = 8'd200; desc_fused = 1'b0;
         while (!layer_done && !wd_hit) begin
            @(negedge clk);
            meas++;
            if (meas == 2) desc_valid = 1'b0;
         end
      end
      chk(layer_cycles == CYC_W'(meas), "R9 cycle count", layer_cycles, meas);
      chk(starts[2] == n1, "R4 unit1 tiles", starts[2], n1);
      chk(starts[3] == n2, "R4 unit2 tiles", starts[3], n2);
      chk(paired == min2(n1, n2), "R4 paired starts", paired, min2(n1, n2));
      chk(starts[0] == rounds, "R3 weight loads", starts[0], rounds);
      if (fu) begin
         chk(starts[1] == min2(rounds, 1), "R7 fused feature loads", starts[1], min2(rounds, 1));
         chk(starts[4] == min2(rounds, 1), "R7 fused stores", starts[4], min2(rounds, 1));
      end else begin
         chk(starts[1] == rounds, "R3 feature loads", starts[1], rounds);
         chk(starts[4] == rounds, "R6 stores", starts[4], rounds);
      end
      chk(viol == 0, "R5 barrier order", viol, 0);
      @(negedge clk);
      chk(layer_done == 1'b0, "R9 done one cycle", layer_done, 0);
      chk(desc_ready == 1'b1, "R9 ready after done", desc_ready, 1);
      // R2: bogus descriptor left no trace
      chk(starts[2] == n1, "R2 busy offer ignored", starts[2], n1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      wd_hit = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(desc_ready == 1'b1, "R1 ready at reset", desc_ready, 1);
      chk({wload_start, fload_start, cu1_start, cu2_start, store_start} == 5'd0,
          "R1 starts idle", {wload_start, fload_start, cu1_start, cu2_start, store_start}, 0);
      chk(layer_done == 1'b0, "R1 done low", layer_done, 0);
      chk(layer_cycles == '0, "R1 cycles zero", layer_cycles, 0);
      rst_n = 1'b1;
      run_layer(0, 0, 1'b0);
      run_layer(3, 3, 1'b0);
      run_layer(5, 2, 1'b0);
      run_layer(1, 4, 1'b0);
      run_layer(4, 1, 1'b1);
      run_layer(0, 3, 1'b0);
      run_layer(2, 0, 1'b1);
      run_layer(1, 1, 1'b1);
      run_layer(0, 0, 1'b1);
      run_layer(12, 9, 1'b0);
      for (int k = 0; k < 24; k++) begin
         run_layer(int'($urandom % 10), int'($urandom % 10), 1'($urandom % 2));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule